// File: doc/BRIEF.md
# Eight-Entry Operand Stack with Fused Add-and-Pop

This block is a small datapath that keeps an operand stack of eight signed fixed-point words, in the style of a floating-point unit's register stack. Commands arrive one per cycle on a valid/opcode pair with one data word. The block can push a zero, push the data word, multiply the top entry in place by the data word, add the top entry into the one below it and then pop, or simply pop. The top entry is st(0) and the one beneath it is st(1).

Storage is eight physical registers with a rotating top pointer. A push moves the pointer down by one and then writes. Logical entry st(i) lives in physical slot (top+i) mod 8. When a push arrives on a full stack, it overwrites the deepest value without stalling and sets a sticky overflow flag. A command that needs more operands than the stack holds changes nothing and sets a sticky underflow flag. The read port always shows st(0), and a status word gives the occupancy and both flags.

Top module: `opstack`

## Requirements
- R1: After reset, occupancy is 0, both flags are 0 and the read port shows 0.
- R2: Opcode 1 (push zero) pushes the value 0. The read port shows 0 and occupancy rises by one.
- R3: Opcode 2 (push operand) pushes the data word. The read port shows that word and the previous st(0) becomes st(1).
- R4: Opcode 3 (multiply) replaces st(0) with the low W bits of st(0) times the data word and leaves occupancy unchanged. On an empty stack it sets the underflow flag and changes nothing else.
- R5: Opcode 4 (add and pop) needs at least two entries. It writes st(0)+st(1), modulo 2^W, into st(1) and pops, so the sum becomes the new st(0) and occupancy falls by one.
- R6: Opcode 5 (pop) needs at least two entries. It discards st(0), so the old st(1) becomes st(0) and occupancy falls by one.
- R7: Occupancy, in status bits [3:0], never exceeds 8. A push at occupancy 8 keeps it at 8 and discards the deepest value. The other seven values keep their order below the new top.
- R8: Status bit 4 is a sticky overflow flag. A push at occupancy 8 sets it, and only reset clears it.
- R9: Status bit 5 is a sticky underflow flag. It is set by opcode 4 or 5 with fewer than two entries, and by opcode 3 on an empty stack. In each of these cases the entries and the occupancy are unchanged, and only reset clears the flag.
- R10: A cycle with cmd_valid low, or with opcode 0, 6 or 7, changes neither the read port nor the status.
- R11: Each accepted command takes one cycle. Its effect shows on the read port and the status in the cycle after the clock edge that accepts it, and back-to-back commands are all applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command valid for this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 push zero, 2 push operand, 3 multiply, 4 add and pop, 5 pop |
| cmd_data | input | W | Operand for push operand and multiply |
| top_value | output | W | Current st(0); 0 when empty |
| status | output | CW+2 | {underflow, overflow, occupancy} |

## Verification
The hardest case to reach from the ports is the wrapped stack after overflow. Here the rotating pointer has lapped the physical registers, and the discarded value can only be seen by draining the stack afterwards. The stimulus pushes ten distinct values in a row and then pops down to one entry. Each value that surfaces is compared against a queue model that drops its deepest element. Empty-stack multiply is reachable only right after reset, so the bench resets again before checking it. A long phase of random commands then mixes in idle and undefined opcodes.

// File: rtl/opstack.sv
module opstack #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic [W-1:0]  top_value,
  output logic [CW+1:0] status
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [2:0] OP_PUSHZ = 3'd1;
  localparam logic [2:0] OP_PUSHD = 3'd2;
  localparam logic [2:0] OP_MUL   = 3'd3;
  localparam logic [2:0] OP_ADDP  = 3'd4;
  localparam logic [2:0] OP_POP   = 3'd5;

  logic [W-1:0]  regs [DEPTH];
  logic [PW-1:0] top;
  logic [CW-1:0] count;
  logic          ovf, unf;

  wire [PW-1:0] top_dn = top - 1'b1;
  wire [PW-1:0] top_up = top + 1'b1;
  wire [W-1:0]  st0 = regs[top];
  wire [W-1:0]  st1 = regs[top_up];
  wire [W-1:0]  prod = st0 * cmd_data;
  wire [W-1:0]  sum = st0 + st1;
  wire          full = (count == CW'(DEPTH));
  wire          has1 = (count != '0);
  wire          has2 = (count > CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      top   <= '0;
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_PUSHZ, OP_PUSHD: begin
          regs[top_dn] <= (cmd_op == OP_PUSHD) ? cmd_data : '0;
          top <= top_dn;
          if (full) ovf <= 1'b1;
          else count <= count + 1'b1;
        end
        OP_MUL: begin
          if (has1) regs[top] <= prod;
          else unf <= 1'b1;
        end
        OP_ADDP: begin
          if (has2) begin
            regs[top_up] <= sum;
            top <= top_up;
            count <= count - 1'b1;
          end else unf <= 1'b1;
        end
        OP_POP: begin
          if (has2) begin
            top <= top_up;
            count <= count - 1'b1;
          end else unf <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign top_value = has1 ? st0 : '0;
  assign status = {unf, ovf, count};
endmodule

// File: rtl/opstack_chk.sv
module opstack_chk #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [W-1:0]  cmd_data,
  input logic [W-1:0]  top_value,
  input logic [CW+1:0] status
);
  wire [CW-1:0] occ = status[CW-1:0];
  wire ovf = status[CW];
  wire unf = status[CW+1];
  wire idle = !cmd_valid || cmd_op == 3'd0 || cmd_op > 3'd5;

  assert_count_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  assert_full_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2) && occ == CW'(DEPTH)
    |=> ovf && occ == CW'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);
  assert_short_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5) && occ < CW'(2)
    |=> unf && $stable(top_value) && $stable(occ));
  assert_push_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd1 |=> top_value == '0);
  assert_push_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd2 |=> top_value == $past(cmd_data));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(top_value) && $stable(status));
endmodule

bind opstack opstack_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .top_value(top_value), .status(status));

// File: tb/opstack_bench.sv
`timescale 1ns/1ps
module opstack_bench;
  localparam int W = 16;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [W-1:0] cmd_data = 0;
  logic [W-1:0] top_value;
  logic [5:0] status;

  opstack #(.W(W), .DEPTH(DEPTH)) u_opstack (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .top_value(top_value), .status(status));

  always #10 clk = ~clk;

  logic [W-1:0] q[$];
  bit m_ovf, m_unf;
  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    check(phase, int'(top_value), (q.size() > 0) ? int'(q[0]) : 0);
    check("R7", int'(status[3:0]), q.size());
    check("R8", int'(status[4]), int'(m_ovf));
    check("R9", int'(status[5]), int'(m_unf));
  endtask

  task automatic model(bit v, logic [2:0] op, logic [W-1:0] d);
    logic [W-1:0] s;
    if (!v) return;
    case (op)
      3'd1, 3'd2: begin
        if (q.size() == DEPTH) begin m_ovf = 1; void'(q.pop_back()); end
        q.push_front(op == 3'd2 ? d : '0);
      end
      3'd3: if (q.size() == 0) m_unf = 1; else begin s = q[0] * d; q[0] = s; end
      3'd4: if (q.size() < 2) m_unf = 1;
            else begin s = q[0] + q[1]; void'(q.pop_front()); q[0] = s; end
      3'd5: if (q.size() < 2) m_unf = 1; else void'(q.pop_front());
      default: ;
    endcase
  endtask

  task automatic step(bit v, logic [2:0] op, logic [W-1:0] d);
    @(negedge clk);
    compare();
    model(v, op, d);
    cmd_valid = v; cmd_op = op; cmd_data = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0;
    q.delete(); m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    phase = "R2"; step(1, 1, 16'h1234);
    phase = "R3"; step(1, 2, 16'h0005); step(1, 2, 16'hFFFD);
    phase = "R4"; step(1, 3, 16'h0007); step(1, 3, 16'h8000); step(1, 3, 16'h0003);
    phase = "R5"; step(1, 2, 16'h7FFF); step(1, 2, 16'h0002); step(1, 4, 0); step(1, 4, 0);
    phase = "R6"; step(1, 5, 0);
    phase = "R10"; step(0, 2, 16'hAAAA); step(1, 0, 16'hBBBB); step(1, 6, 16'hCCCC); step(1, 7, 16'hDDDD);
    phase = "R9"; step(1, 5, 0); step(1, 4, 0); step(1, 5, 0); step(0, 0, 0);
    do_reset();
    phase = "R9"; step(1, 3, 16'h0009); step(1, 5, 0); step(0, 0, 0);
    do_reset();
    phase = "R7";
    for (int i = 0; i < 10; i++) step(1, 2, 16'(16'h0100 + i));
    for (int i = 0; i < 8; i++) step(1, 5, 0);
    phase = "R8"; step(1, 1, 0); step(0, 0, 0);
    do_reset();
    phase = "R11";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), 16'($urandom));
    step(0, 0, 0);
    step(0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule